// File: doc/BRIEF.md
# Descriptor Ring Pointer Queue

This block is the hardware half of a circular descriptor queue whose entries live in shared memory and are 32 bytes each. Software and hardware each own one of the two pointers: one side produces entries by moving the write pointer and the other side consumes them by moving the read pointer. A parameter selects whether the hardware side is the producer or the consumer. Software programs a base address, a ring depth, its own pointer and two fill thresholds through a simple select/data write port. The hardware engine requests one-entry advances through a strobe and receives a same-cycle acknowledge.

Pointers are exposed as byte offsets, which are the entry index times 32. The block derives the number of valid entries and the number of free slots from the two pointers. It flags the empty, full, almost-empty and almost-full states. It also presents the absolute address of the descriptor the hardware side will touch next. The base address, the depth and the hardware-owned pointer are protected: a write to one of them lands only while its own bit in a write-gate word is set.

Top module: `desc_ring_queue`

## Requirements
- R1: After reset the base is 0, the depth is 2^IDX_W entries, both pointers are 0, the valid count is 0 and the free count is 2^IDX_W-1, the empty and almost-empty flags are high, and the full and almost-full flags are low.
- R2: Pointer writes take the entry index from cfgData bits [IDX_W+4:5] and ignore bits [4:0]. Pointer outputs read back as index times 32. hwDescAddr equals the base plus the byte offset of the hardware-owned pointer.
- R3: cfgSel encodes the fields: 0 is the gate word in bits [2:0], 1 is the base, 2 is the depth, 3 is the software pointer, 4 is the hardware pointer, 5 is the almost-empty threshold and 6 is the almost-full threshold. Gate bit 2 enables base writes, bit 1 enables depth writes and bit 0 enables hardware-pointer writes, and a write is ignored while its bit is clear. The software pointer and both thresholds are always writable.
- R4: The depth is written as the entry count shifted left by 3. The write is accepted only when that count is a power of two from 2 to 2^IDX_W, and any other value is ignored.
- R5: Indices wrap modulo the depth. A pointer changes only on an accepted write or an accepted advance.
- R6: validCnt is (write index - read index) mod depth, and freeCnt is depth - 1 - validCnt.
- R7: ringEmpty is high when the two indices are equal. ringFull is high when validCnt is depth - 1, so at most depth - 1 entries are ever outstanding.
- R8: hwAdv is acknowledged in the same cycle unless the ring is full (hardware producer) or empty (hardware consumer). An acknowledged advance moves the hardware pointer one entry forward at the next edge. A refused advance has no effect.
- R9: A hardware-pointer write that is accepted in the same cycle as hwAdv takes priority. hwAck is low in that cycle and the written value is loaded.
- R10: almostEmpty is high when validCnt is at most the almost-empty threshold, and almostFull is high when validCnt is at least the almost-full threshold. Both thresholds use cfgData bits [IDX_W-1:0] and reset to 0 and 2^IDX_W-1 respectively.
- R11: With HW_PRODUCER=1 the hardware owns the write pointer and cfgSel 3 writes the read pointer. With HW_PRODUCER=0 the roles are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Field select for the write |
| cfgData | input | 32 | Write data |
| hwAdv | input | 1 | Hardware request to advance its pointer one entry |
| hwAck | output | 1 | Advance accepted this cycle |
| baseAddr | output | ADDR_W | Ring base address |
| depthEntries | output | IDX_W+1 | Ring depth in entries |
| wrPtr | output | ADDR_W | Write pointer, byte offset |
| rdPtr | output | ADDR_W | Read pointer, byte offset |
| hwDescAddr | output | ADDR_W | Absolute address of the hardware side's current descriptor |
| validCnt | output | IDX_W | Entries outstanding |
| freeCnt | output | IDX_W | Slots still usable by the producer |
| ringEmpty | output | 1 | No entries outstanding |
| ringFull | output | 1 | depth - 1 entries outstanding |
| almostEmpty | output | 1 | validCnt at or below its threshold |
| almostFull | output | 1 | validCnt at or above its threshold |

## Verification
Every register is written at the rising edge that samples the write or the advance, and the stored value and every count, flag and address derived from it are visible one cycle later. hwAck is combinational on hwAdv, the pending write and the current counts, so it is due in the same cycle as the request. The bench drives inputs just after the falling edge and compares all outputs against its model 1 ns later. It then steps the model at the rising edge, so same-cycle results and one-cycle-late results are both judged in the cycle they are due. Two instances, one for each ownership role, receive the same directed and random stimulus.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

  localparam int CFG_W       = 32;
  localparam int DESC_SHIFT  = 5;   // 32-byte descriptors
  localparam int DEPTH_SHIFT = 3;   // depth field holds entries << 3

  // Gate-word bit positions
  localparam int GATE_HWPTR_BIT = 0;
  localparam int GATE_DEPTH_BIT = 1;
  localparam int GATE_BASE_BIT  = 2;

  typedef enum logic [2:0] {
    SEL_GATE  = 3'd0,
    SEL_BASE  = 3'd1,
    SEL_DEPTH = 3'd2,
    SEL_SWPTR = 3'd3,
    SEL_HWPTR = 3'd4,
    SEL_AETH  = 3'd5,
    SEL_AFTH  = 3'd6,
    SEL_NONE  = 3'd7
  } cfgSel_e;

  typedef struct packed {
    logic ldBase;
    logic ldDepth;
    logic ldSwPtr;
    logic ldHwPtr;
    logic ldAeTh;
    logic ldAfTh;
    logic advHw;
  } ringStrobe_t;

endpackage

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
#(
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [2:0]         cfgSel,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               hwAdv,
  input  logic               ringFull,
  input  logic               ringEmpty,
  output ringStrobe_t        strobe,
  output logic [2:0]         gateWord,
  output logic               hwAck
);

  localparam int CAND_W = CFG_W - DEPTH_SHIFT;
  localparam logic [CAND_W-1:0] MAX_ENT = CAND_W'(1) << IDX_W;

  cfgSel_e           selE;
  logic [2:0]        gateQ;
  logic [CAND_W-1:0] depthCand;
  logic              depthOk;
  logic              hwBlocked;

  assign selE      = cfgSel_e'(cfgSel);
  assign depthCand = cfgData[CFG_W-1:DEPTH_SHIFT];
  assign depthOk   = (depthCand >= CAND_W'(2)) && (depthCand <= MAX_ENT)
                   && ((depthCand & (depthCand - CAND_W'(1))) == '0);

  generate
    if (HW_PRODUCER) begin : g_prod
      assign hwBlocked = ringFull;
    end else begin : g_cons
      assign hwBlocked = ringEmpty;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else if (cfgWr && selE == SEL_GATE) gateQ <= cfgData[2:0];
  end

  always_comb begin
    strobe         = '0;
    strobe.ldBase  = cfgWr && selE == SEL_BASE  && gateQ[GATE_BASE_BIT];
    strobe.ldDepth = cfgWr && selE == SEL_DEPTH && gateQ[GATE_DEPTH_BIT] && depthOk;
    strobe.ldSwPtr = cfgWr && selE == SEL_SWPTR;
    strobe.ldHwPtr = cfgWr && selE == SEL_HWPTR && gateQ[GATE_HWPTR_BIT];
    strobe.ldAeTh  = cfgWr && selE == SEL_AETH;
    strobe.ldAfTh  = cfgWr && selE == SEL_AFTH;
    strobe.advHw   = hwAdv && !hwBlocked && !strobe.ldHwPtr;
  end

  assign hwAck    = strobe.advHw;
  assign gateWord = gateQ;

endmodule

// File: rtl/desc_ring_dp.sv
module desc_ring_dp
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  input  logic [CFG_W-1:0]  cfgData,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [IDX_W:0]    depthEntries,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] hwDescAddr,
  output logic [IDX_W-1:0]  validCnt,
  output logic [IDX_W-1:0]  freeCnt,
  output logic              ringEmpty,
  output logic              ringFull,
  output logic              almostEmpty,
  output logic              almostFull
);

  localparam logic [IDX_W:0] RST_ENT = (IDX_W+1)'(1) << IDX_W;

  logic [ADDR_W-1:0] baseQ;
  logic [IDX_W:0]    entQ;
  logic [IDX_W-1:0]  swIdxQ, hwIdxQ, aeThQ, afThQ;
  logic [IDX_W-1:0]  idxMask, swEff, hwEff, hwNext, wrEff, rdEff, cnt;

  // Indices are stored raw and masked where used, so a depth change never
  // needs to rewrite them.
  assign idxMask = IDX_W'(entQ - (IDX_W+1)'(1));
  assign swEff   = swIdxQ & idxMask;
  assign hwEff   = hwIdxQ & idxMask;
  assign hwNext  = (hwEff + IDX_W'(1)) & idxMask;

  generate
    if (HW_PRODUCER) begin : g_hwWr
      assign wrEff = hwEff;
      assign rdEff = swEff;
    end else begin : g_hwRd
      assign wrEff = swEff;
      assign rdEff = hwEff;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      entQ   <= RST_ENT;
      swIdxQ <= '0;
      hwIdxQ <= '0;
      aeThQ  <= '0;
      afThQ  <= '1;
    end else begin
      if (strobe.ldBase)  baseQ  <= ADDR_W'(cfgData);
      if (strobe.ldDepth) entQ   <= cfgData[DEPTH_SHIFT +: IDX_W+1];
      if (strobe.ldSwPtr) swIdxQ <= cfgData[DESC_SHIFT +: IDX_W];
      if (strobe.ldHwPtr)     hwIdxQ <= cfgData[DESC_SHIFT +: IDX_W];
      else if (strobe.advHw)  hwIdxQ <= hwNext;
      if (strobe.ldAeTh)  aeThQ  <= cfgData[IDX_W-1:0];
      if (strobe.ldAfTh)  afThQ  <= cfgData[IDX_W-1:0];
    end
  end

  assign cnt          = (wrEff - rdEff) & idxMask;
  assign validCnt     = cnt;
  assign freeCnt      = idxMask - cnt;
  assign ringEmpty    = (cnt == '0);
  assign ringFull     = (cnt == idxMask);
  assign almostEmpty  = (cnt <= aeThQ);
  assign almostFull   = (cnt >= afThQ);
  assign baseAddr     = baseQ;
  assign depthEntries = entQ;
  assign wrPtr        = ADDR_W'(wrEff) << DESC_SHIFT;
  assign rdPtr        = ADDR_W'(rdEff) << DESC_SHIFT;
  assign hwDescAddr   = baseQ + (ADDR_W'(hwEff) << DESC_SHIFT);

endmodule

// File: rtl/desc_ring_queue.sv
module desc_ring_queue
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [2:0]        cfgSel,
  input  logic [31:0]       cfgData,
  input  logic              hwAdv,
  output logic              hwAck,
  output logic [ADDR_W-1:0] baseAddr,
  output logic [IDX_W:0]    depthEntries,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr,
  output logic [ADDR_W-1:0] hwDescAddr,
  output logic [IDX_W-1:0]  validCnt,
  output logic [IDX_W-1:0]  freeCnt,
  output logic              ringEmpty,
  output logic              ringFull,
  output logic              almostEmpty,
  output logic              almostFull
);

  ringStrobe_t strobe;
  logic [2:0]  gateWord;

  desc_ring_ctrl #(.IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSel(cfgSel), .cfgData(cfgData),
    .hwAdv(hwAdv), .ringFull(ringFull), .ringEmpty(ringEmpty),
    .strobe(strobe), .gateWord(gateWord), .hwAck(hwAck)
  );

  desc_ring_dp #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgData(cfgData),
    .baseAddr(baseAddr), .depthEntries(depthEntries), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .hwDescAddr(hwDescAddr), .validCnt(validCnt), .freeCnt(freeCnt),
    .ringEmpty(ringEmpty), .ringFull(ringFull),
    .almostEmpty(almostEmpty), .almostFull(almostFull)
  );

endmodule

// File: rtl/desc_ring_chk.sv
module desc_ring_chk #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter bit HW_PRODUCER = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic [2:0]        cfgSel,
  input logic              hwAck,
  input logic [2:0]        gateWord,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [IDX_W:0]    depthEntries,
  input logic [ADDR_W-1:0] wrPtr,
  input logic [ADDR_W-1:0] rdPtr,
  input logic [IDX_W-1:0]  validCnt,
  input logic [IDX_W-1:0]  freeCnt,
  input logic              ringEmpty,
  input logic              ringFull
);

  logic [IDX_W-1:0] hwIdx, maskC;
  logic             depthWr;

  assign hwIdx   = HW_PRODUCER ? wrPtr[5 +: IDX_W] : rdPtr[5 +: IDX_W];
  assign maskC   = IDX_W'(depthEntries - (IDX_W+1)'(1));
  assign depthWr = cfgWr && cfgSel == 3'd2;

  assert_count_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, validCnt} + {1'b0, freeCnt}) == depthEntries - (IDX_W+1)'(1));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(ringEmpty && ringFull));

  assert_full_no_free_R7: assert property (@(posedge clk) disable iff (!rstN)
    ringFull |-> freeCnt == '0);

  assert_depth_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(depthEntries) && depthEntries >= (IDX_W+1)'(2));

  assert_blocked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (HW_PRODUCER ? ringFull : ringEmpty) |-> !hwAck);

  assert_hw_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hwAck && !depthWr) |=> hwIdx == (($past(hwIdx) + IDX_W'(1)) & $past(maskC)));

  assert_gate_base_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgSel == 3'd1 && !gateWord[2]) |=> $stable(baseAddr));

  assert_gate_depth_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgSel == 3'd2 && !gateWord[1]) |=> $stable(depthEntries));

  assert_hwptr_priority_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgSel == 3'd4 && gateWord[0]) |-> !hwAck);

  assert_ptr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgWr && !hwAck) |=> ($stable(wrPtr) && $stable(rdPtr)));

endmodule

bind desc_ring_queue desc_ring_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HW_PRODUCER(HW_PRODUCER)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgSel(cfgSel), .hwAck(hwAck),
  .gateWord(gateWord), .baseAddr(baseAddr), .depthEntries(depthEntries),
  .wrPtr(wrPtr), .rdPtr(rdPtr), .validCnt(validCnt), .freeCnt(freeCnt),
  .ringEmpty(ringEmpty), .ringFull(ringFull)
);

// File: tb/desc_ring_queue_bench.sv
`timescale 1ns/1ps
module desc_ring_queue_bench;

  localparam int IDX_W = 10;
  localparam int MAXE  = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        iWr = 1'b0;
  logic [2:0]  iSel = 3'd0;
  logic [31:0] iData = 32'd0;
  logic        iAdv = 1'b0;

  logic        oAck[2];
  logic [31:0] oBase[2], oWr[2], oRd[2], oHwA[2];
  logic [IDX_W:0]   oDepth[2];
  logic [IDX_W-1:0] oValid[2], oFree[2];
  logic        oEmpty[2], oFull[2], oAe[2], oAf[2];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  desc_ring_queue #(.IDX_W(IDX_W), .HW_PRODUCER(1'b0)) u_desc_ring_queue (
    .clk(clk), .rstN(rstN), .cfgWr(iWr), .cfgSel(iSel), .cfgData(iData), .hwAdv(iAdv),
    .hwAck(oAck[0]), .baseAddr(oBase[0]), .depthEntries(oDepth[0]), .wrPtr(oWr[0]),
    .rdPtr(oRd[0]), .hwDescAddr(oHwA[0]), .validCnt(oValid[0]), .freeCnt(oFree[0]),
    .ringEmpty(oEmpty[0]), .ringFull(oFull[0]), .almostEmpty(oAe[0]), .almostFull(oAf[0]));

  desc_ring_queue #(.IDX_W(IDX_W), .HW_PRODUCER(1'b1)) u_prod (
    .clk(clk), .rstN(rstN), .cfgWr(iWr), .cfgSel(iSel), .cfgData(iData), .hwAdv(iAdv),
    .hwAck(oAck[1]), .baseAddr(oBase[1]), .depthEntries(oDepth[1]), .wrPtr(oWr[1]),
    .rdPtr(oRd[1]), .hwDescAddr(oHwA[1]), .validCnt(oValid[1]), .freeCnt(oFree[1]),
    .ringEmpty(oEmpty[1]), .ringFull(oFull[1]), .almostEmpty(oAe[1]), .almostFull(oAf[1]));

  // Behavioural model, index 0 = hardware consumer, 1 = hardware producer
  longint mBase[2], mEnt[2], mSw[2], mHw[2], mAe[2], mAf[2], mGate[2];

  function automatic longint wrI(int r);
    return r ? mHw[r] % mEnt[r] : mSw[r] % mEnt[r];
  endfunction
  function automatic longint rdI(int r);
    return r ? mSw[r] % mEnt[r] : mHw[r] % mEnt[r];
  endfunction
  function automatic longint vld(int r);
    return (wrI(r) - rdI(r) + mEnt[r]) % mEnt[r];
  endfunction
  function automatic bit ackE(int r);
    bit blocked = r ? (vld(r) == mEnt[r] - 1) : (vld(r) == 0);
    bit hwLoad  = iWr && iSel == 3'd4 && mGate[r][0];
    return iAdv && !hwLoad && !blocked;
  endfunction

  task automatic chk(string req, string what, int r, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s inst%0d actual=%0h expected=%0h @%0t", req, what, r, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    for (int r = 0; r < 2; r++) begin
      longint hwOff = (r ? wrI(r) : rdI(r)) * 32;
      chk("R3",  "baseAddr",    r, oBase[r],  mBase[r]);
      chk("R4",  "depth",       r, oDepth[r], mEnt[r]);
      chk("R5",  "wrPtr",       r, oWr[r],    wrI(r) * 32);
      chk("R5",  "rdPtr",       r, oRd[r],    rdI(r) * 32);
      chk("R2",  "hwDescAddr",  r, oHwA[r],   (mBase[r] + hwOff) & 64'hFFFF_FFFF);
      chk("R6",  "validCnt",    r, oValid[r], vld(r));
      chk("R6",  "freeCnt",     r, oFree[r],  mEnt[r] - 1 - vld(r));
      chk("R7",  "ringEmpty",   r, oEmpty[r], vld(r) == 0);
      chk("R7",  "ringFull",    r, oFull[r],  vld(r) == mEnt[r] - 1);
      chk("R10", "almostEmpty", r, oAe[r],    vld(r) <= mAe[r]);
      chk("R10", "almostFull",  r, oAf[r],    vld(r) >= mAf[r]);
      chk("R8",  "hwAck",       r, oAck[r],   ackE(r));
    end
  endtask

  task automatic modelEdge();
    for (int r = 0; r < 2; r++) begin
      longint nHw = mHw[r];
      longint d = iData;
      longint cand = d >> 3;
      if (ackE(r)) nHw = (mHw[r] % mEnt[r] + 1) % mEnt[r];
      if (iWr) begin
        case (iSel)
          3'd0: mGate[r] = d & 7;
          3'd1: if (mGate[r][2]) mBase[r] = d;
          3'd2: if (mGate[r][1] && cand >= 2 && cand <= MAXE && (cand & (cand - 1)) == 0)
                  mEnt[r] = cand;
          3'd3: mSw[r] = (d >> 5) & (MAXE - 1);
          3'd4: if (mGate[r][0]) nHw = (d >> 5) & (MAXE - 1);
          3'd5: mAe[r] = d & (MAXE - 1);
          3'd6: mAf[r] = d & (MAXE - 1);
          default: ;
        endcase
      end
      mHw[r] = nHw;
    end
  endtask

  task automatic drive(input bit w, input logic [2:0] s, input logic [31:0] d, input bit a);
    iWr = w; iSel = s; iData = d; iAdv = a;
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic step(input bit w, input logic [2:0] s, input logic [31:0] d, input bit a);
    drive(w, s, d, a);
    #1;
    compareAll();
    tick();
  endtask

  initial begin
    for (int r = 0; r < 2; r++) begin
      mBase[r] = 0; mEnt[r] = MAXE; mSw[r] = 0; mHw[r] = 0;
      mAe[r] = 0; mAf[r] = MAXE - 1; mGate[r] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    for (int r = 0; r < 2; r++) begin
      chk("R1", "rst validCnt", r, oValid[r], 0);
      chk("R1", "rst freeCnt",  r, oFree[r],  MAXE - 1);
      chk("R1", "rst depth",    r, oDepth[r], MAXE);
      chk("R1", "rst empty",    r, oEmpty[r], 1);
      chk("R1", "rst almostE",  r, oAe[r],    1);
      chk("R1", "rst almostF",  r, oAf[r],    0);
      chk("R1", "rst ptrs",     r, oWr[r] | oRd[r] | oBase[r], 0);
    end
    // R3: base write with gate clear is ignored
    step(1, 3'd1, 32'h0000_1000, 0);
    #1;
    chk("R3", "gated base", 0, oBase[0], 0);
    chk("R3", "gated base", 1, oBase[1], 0);
    step(1, 3'd0, 32'd7, 0);
    step(1, 3'd1, 32'h8000_0040, 0);
    step(1, 3'd2, 32'd8 << 3, 0);
    step(1, 3'd5, 32'd1, 0);
    step(1, 3'd6, 32'd6, 0);
    // R4: illegal depth values are ignored
    step(1, 3'd2, 32'd6 << 3, 0);
    step(1, 3'd2, 32'd0, 0);
    step(1, 3'd2, 32'd2048 << 3, 0);
    #1;
    chk("R4", "depth kept", 0, oDepth[0], 8);
    chk("R4", "depth kept", 1, oDepth[1], 8);
    step(1, 3'd0, 32'd0, 0);
    step(1, 3'd2, 32'd4 << 3, 0);
    // R8/R11: producer fills to depth-1 then refuses, consumer refuses while empty
    repeat (10) step(0, 3'd7, 32'd0, 1);
    #1;
    chk("R8",  "producer full", 1, oFull[1], 1);
    chk("R11", "producer wrPtr", 1, oWr[1], 7 * 32);
    chk("R11", "consumer rdPtr", 0, oRd[0], 0);
    // R2: low byte bits of a pointer write are ignored
    step(1, 3'd3, (32'd3 << 5) | 32'h1f, 1);
    #1;
    chk("R2", "sw ptr low bits", 0, oWr[0], 3 * 32);
    repeat (6) step(0, 3'd7, 32'd0, 1);
    // R9: accepted hardware pointer write beats a simultaneous advance
    step(1, 3'd0, 32'd1, 0);
    drive(1, 3'd4, 32'd2 << 5, 1);
    #1;
    chk("R9", "hwAck suppressed", 0, oAck[0], 0);
    chk("R9", "hwAck suppressed", 1, oAck[1], 0);
    compareAll();
    tick();
    // R5: index past depth wraps
    step(1, 3'd3, 32'd12 << 5, 0);
    repeat (8) step(0, 3'd7, 32'd0, 1);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      int sel = $urandom % 10;
      logic [31:0] d;
      case (sel)
        0: d = $urandom % 8;
        2: begin
          int pick = $urandom % 6;
          d = (pick == 0) ? 32'd24 : (32'd1 << (pick + 1)) << 3;
        end
        3, 4: d = (($urandom % 32) << 5) | ($urandom % 32);
        5, 6: d = $urandom % 10;
        default: d = $urandom;
      endcase
      step(($urandom % 3) == 0, (sel > 7) ? 3'd7 : 3'(sel), d, ($urandom % 10) < 7);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule